// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers character frames from an asynchronous serial line. An idle line rests at the mark level. A frame opens with a start bit at the space level. Then come five to eight data bits, an optional parity bit and one or two stop bits at the mark level. Static mode inputs select four things:

- the character length;
- whether parity is present, and whether it follows the odd or the even rule;
- the number of stop bits;
- the order in which the data bits arrive.

A polarity input selects whether the line is read as is or inverted. The block thus pairs with a transmitter that uses the same settings.

The line passes through a synchronizer. Bit timing comes from a one-cycle tick at sixteen times the baud rate, supplied from outside. A falling edge starts a timing window, and the start bit is accepted only if the line is still at the space level half a bit later. Every later bit is sampled once, at its centre.

When the last stop bit has been sampled, the block presents the character right-justified, with unused upper bits at zero. At the same time it raises a one-cycle valid strobe, and a parity error flag and a framing error flag that are qualified by that strobe.

Top module: `serial_frame_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_par_err` and `out_frm_err` are 0 and `out_data` is 0.
- R2: With `cfg_msb_first`=0, the first data bit after the start bit lands in bit 0 of `out_data`. The number of data bits is `cfg_len`+5 (0→5, 1→6, 2→7, 3→8). The stop bits follow the data, or follow the parity bit when `cfg_par_en`=1.
- R3: With `cfg_msb_first`=1, the first data bit received lands in bit (`cfg_len`+4) of `out_data`, and the last one lands in bit 0.
- R4: Bits of `out_data` above the selected length are 0 whenever `out_valid` is 1.
- R5: When `cfg_par_en`=1, `out_par_err` is 1 if the count of ones over the data bits and the parity bit is odd while `cfg_par_odd`=0, or even while `cfg_par_odd`=1. When `cfg_par_en`=0, `out_par_err` stays 0.
- R6: `out_frm_err` is 1 if any expected stop bit is sampled at the space level. With `cfg_two_stop`=1, both stop bits are checked.
- R7: With `cfg_invert`=1, the line is inverted before start detection and sampling. The idle line is then low, the start bit high, and the data bits are the complements of the logical values.
- R8: A space level that lasts less than half a bit time is not taken as a start bit. The receiver returns to idle and produces no `out_valid`.
- R9: `out_valid` is a one-cycle pulse issued at the sample of the last stop bit. The error flags are 1 only in that cycle. A start bit that follows the stop bit immediately is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input line |
| os_tick | input | 1 | One-cycle tick at 16 times the baud rate |
| cfg_len | input | 2 | Data bit count minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity rule, 0 = even parity rule |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| cfg_msb_first | input | 1 | 1 = most significant data bit arrives first |
| cfg_invert | input | 1 | 1 = line is inverted |
| out_data | output | 8 | Received character, right-justified |
| out_valid | output | 1 | One-cycle strobe for a finished frame |
| out_par_err | output | 1 | Parity mismatch, qualified by out_valid |
| out_frm_err | output | 1 | Stop bit sampled at space level, qualified by out_valid |

## Verification
A parity fault and a framing fault are reported in the same cycle, since both are taken from one frame at its last stop sample. The random frames inject a flipped parity bit and a stop bit held at space level independently, so some frames carry both faults. The bench then compares each flag on its own against the expected fault for that frame.

The other coincidence is the end of one frame with the start edge of the next. A directed pair of frames sent with no idle gap provokes it, and it is judged by the second character being decoded intact.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic invert,
   output logic dout
);
   initial begin
      if (STAGES < 2) $error("srx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1] ^ invert;
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
   import srx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int DATA_W     = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line,
   input  logic [3:0] nbits,
   input  logic       par_en,
   input  logic       two_stop,
   output logic       frame_open,
   output logic       data_stb,
   output logic       par_stb,
   output logic       frame_done,
   output logic       frm_err
);
   localparam int CW  = $clog2(OVERSAMPLE);
   localparam int MID = OVERSAMPLE / 2;
   localparam int BW  = $clog2(DATA_W);

   initial begin
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0)
         $error("srx_ctrl: OVERSAMPLE must be even and at least 4");
   end

   rx_state_t      state;
   logic [CW-1:0]  tcnt;
   logic [BW-1:0]  bcnt;
   logic           stop_bad;
   logic           mid_hit, full_hit, last_data, last_stop;

   assign mid_hit    = tick && (tcnt == CW'(MID - 1));
   assign full_hit   = tick && (tcnt == CW'(OVERSAMPLE - 1));
   assign last_data  = ({1'b0, bcnt} == (BW+1)'(nbits - 4'd1));
   assign last_stop  = (bcnt == BW'(two_stop));
   assign frame_open = (state == RX_START) && mid_hit && !line;
   assign data_stb   = (state == RX_DATA) && full_hit;
   assign par_stb    = (state == RX_PAR) && full_hit;
   assign frame_done = (state == RX_STOP) && full_hit && last_stop;
   assign frm_err    = stop_bad | !line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         tcnt     <= '0;
         bcnt     <= '0;
         stop_bad <= 1'b0;
      end else begin
         case (state)
            RX_IDLE: begin
               tcnt <= '0;
               bcnt <= '0;
               if (!line) state <= RX_START;
            end
            RX_START: begin
               if (mid_hit) begin
                  tcnt     <= '0;
                  stop_bad <= 1'b0;
                  state    <= line ? RX_IDLE : RX_DATA;
               end else if (tick) begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            RX_DATA: begin
               if (full_hit) begin
                  tcnt <= '0;
                  if (last_data) begin
                     bcnt  <= '0;
                     state <= par_en ? RX_PAR : RX_STOP;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end else if (tick) begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            RX_PAR: begin
               if (full_hit) begin
                  tcnt  <= '0;
                  state <= RX_STOP;
               end else if (tick) begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (full_hit) begin
                  tcnt     <= '0;
                  stop_bad <= stop_bad | !line;
                  if (last_stop) state <= RX_IDLE;
                  else           bcnt  <= bcnt + 1'b1;
               end else if (tick) begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R8: a start window whose mid sample sees mark level goes back to idle
   a_r8_glitch_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_START && mid_hit && line) |=> (state == RX_IDLE));

   // R2: once data begins, the frame never goes back to the start phase
   a_r2_frame_order: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_DATA) |=> (state != RX_START && state != RX_IDLE));

   // R6: the stop phase runs only as long as the selected stop count
   a_r6_stop_count: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_STOP) |-> (bcnt <= BW'(two_stop)));
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              data_stb,
   input  logic              par_stb,
   input  logic              bit_in,
   input  logic              msb_first,
   input  logic [3:0]        nbits,
   input  logic              par_en,
   input  logic              par_odd,
   output logic [DATA_W-1:0] data_o,
   output logic              par_err_o
);
   initial begin
      if (DATA_W < 4 || DATA_W > 15) $error("srx_shift: DATA_W out of range");
   end

   logic [DATA_W-1:0] sh;
   logic              acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         acc <= 1'b0;
      end else if (clear) begin
         sh  <= '0;
         acc <= 1'b0;
      end else if (data_stb) begin
         acc <= acc ^ bit_in;
         if (msb_first) sh <= {sh[DATA_W-2:0], bit_in};
         else           sh <= {bit_in, sh[DATA_W-1:1]};
      end else if (par_stb) begin
         acc <= acc ^ bit_in;
      end
   end

   always_comb begin
      if (msb_first) data_o = sh;
      else           data_o = sh >> (DATA_W - int'(nbits));
   end

   assign par_err_o = par_en & (acc ^ par_odd);
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_line,
   input  logic       os_tick,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic       cfg_two_stop,
   input  logic       cfg_msb_first,
   input  logic       cfg_invert,
   output logic [7:0] out_data,
   output logic       out_valid,
   output logic       out_par_err,
   output logic       out_frm_err
);
   localparam int DATA_W   = 8;
   localparam int MIN_BITS = DATA_W - 3;

   logic             line_s;
   logic [3:0]       nbits;
   logic             frame_open, data_stb, par_stb, frame_done, frm_err;
   logic [DATA_W-1:0] data_w;
   logic             par_err_w;

   assign nbits = 4'(cfg_len) + 4'(MIN_BITS);

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_line), .invert(cfg_invert), .dout(line_s));

   srx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s), .nbits(nbits),
      .par_en(cfg_par_en), .two_stop(cfg_two_stop), .frame_open(frame_open),
      .data_stb(data_stb), .par_stb(par_stb), .frame_done(frame_done),
      .frm_err(frm_err));

   srx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clear(frame_open), .data_stb(data_stb),
      .par_stb(par_stb), .bit_in(line_s), .msb_first(cfg_msb_first), .nbits(nbits),
      .par_en(cfg_par_en), .par_odd(cfg_par_odd), .data_o(data_w),
      .par_err_o(par_err_w));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data    <= '0;
         out_valid   <= 1'b0;
         out_par_err <= 1'b0;
         out_frm_err <= 1'b0;
      end else begin
         out_valid   <= frame_done;
         out_par_err <= frame_done & par_err_w;
         out_frm_err <= frame_done & frm_err;
         if (frame_done) out_data <= data_w;
      end
   end

   // R9: the valid strobe lasts one cycle
   a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R9: error flags appear only together with valid
   a_r9_flags_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      (out_par_err || out_frm_err) |-> out_valid);

   // R5: no parity error when parity is off
   a_r5_par_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      out_par_err |-> cfg_par_en);

   // R4: unused upper bits read as zero
   a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_data >> (int'(cfg_len) + MIN_BITS)) == 8'd0));
endmodule

// File: tb/serial_frame_rx_test.sv
`timescale 1ns/1ps
module serial_frame_rx_test;
   localparam int TDIV = 3;
   localparam int OS   = 16;
   localparam int BITC = TDIV * OS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       os_tick = 1'b0;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
   logic       cfg_msb_first = 1'b0, cfg_invert = 1'b0;
   logic [7:0] out_data;
   logic       out_valid, out_par_err, out_frm_err;

   int n_chk = 0, n_bad = 0, cap_n = 0;
   logic [7:0] cap_data;
   logic       cap_par, cap_frm;
   bit         done = 0;

   always #2 clk = ~clk;

   serial_frame_rx uut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_two_stop(cfg_two_stop), .cfg_msb_first(cfg_msb_first),
      .cfg_invert(cfg_invert), .out_data(out_data), .out_valid(out_valid),
      .out_par_err(out_par_err), .out_frm_err(out_frm_err));

   initial begin
      forever begin
         repeat (TDIV - 1) @(negedge clk) os_tick = 1'b0;
         @(negedge clk) os_tick = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (out_valid) begin
         cap_n++;
         cap_data = out_data;
         cap_par  = out_par_err;
         cap_frm  = out_frm_err;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mask_data(logic [7:0] d, logic [1:0] len);
      return d & 8'((9'd1 << (int'(len) + 5)) - 9'd1);
   endfunction

   function automatic logic par_bit(logic [7:0] d, logic odd);
      return (^d) ^ odd;
   endfunction

   task automatic line_bit(logic v, int clocks);
      rx_line = v ^ cfg_invert;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_frame(logic [7:0] d, bit bad_par, int bad_stop);
      logic [7:0] m = mask_data(d, cfg_len);
      int n = int'(cfg_len) + 5;
      line_bit(1'b0, BITC);
      for (int i = 0; i < n; i++)
         line_bit(cfg_msb_first ? m[n-1-i] : m[i], BITC);
      if (cfg_par_en) line_bit(par_bit(m, cfg_par_odd) ^ bad_par, BITC);
      line_bit(bad_stop != 1, BITC);
      if (cfg_two_stop) line_bit(bad_stop != 2, BITC);
   endtask

   task automatic frame_case(string req, logic [7:0] d, bit bad_par, int bad_stop);
      logic [7:0] m = mask_data(d, cfg_len);
      line_bit(1'b1, 2 * BITC);
      cap_n = 0;
      send_frame(d, bad_par, bad_stop);
      line_bit(1'b1, 2 * BITC);
      check({req, " valid count"}, cap_n, 1);
      check({req, " data"}, cap_data, m);
      check("R5 parity flag", cap_par, cfg_par_en & bad_par);
      check("R6 framing flag", cap_frm, bad_stop != 0);
   endtask

   initial begin
      void'($urandom(32'd9137));
      repeat (3) @(negedge clk);
      check("R1 valid in reset", out_valid, 0);
      check("R1 data in reset", out_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 flags after reset", {out_valid, out_par_err, out_frm_err}, 0);

      // R2 directed: 8 bits, LSB first, no parity
      frame_case("R2", 8'hA5, 0, 0);
      // R3 directed: MSB first, 5 bits
      cfg_msb_first = 1; cfg_len = 2'd0;
      frame_case("R3", 8'h13, 0, 0);
      // R4: upper bits zero for 6 bits with all-ones input
      cfg_msb_first = 0; cfg_len = 2'd1;
      frame_case("R4", 8'hFF, 0, 0);
      // R5 odd parity, both faults in one frame, two stops
      cfg_par_en = 1; cfg_par_odd = 1; cfg_two_stop = 1; cfg_len = 2'd3;
      frame_case("R6", 8'h3C, 1, 2);
      // R7 inverted line
      cfg_invert = 1; cfg_par_en = 0; cfg_two_stop = 0;
      frame_case("R7", 8'h6E, 0, 0);
      cfg_invert = 0;

      // R8 start glitch shorter than half a bit
      line_bit(1'b1, 2 * BITC);
      cap_n = 0;
      line_bit(1'b0, 4 * TDIV);
      line_bit(1'b1, 3 * BITC);
      check("R8 glitch no valid", cap_n, 0);
      frame_case("R8 after glitch", 8'h81, 0, 0);

      // R9 back-to-back frames with no gap
      line_bit(1'b1, 2 * BITC);
      cap_n = 0;
      send_frame(8'h5A, 0, 0);
      send_frame(8'hC3, 0, 0);
      line_bit(1'b1, 2 * BITC);
      check("R9 back-to-back count", cap_n, 2);
      check("R9 back-to-back data", cap_data, 8'hC3);

      for (int k = 0; k < 110; k++) begin
         logic [7:0] d;
         bit bp;
         int bs;
         cfg_len       = 2'($urandom_range(0, 3));
         cfg_par_en    = 1'($urandom_range(0, 1));
         cfg_par_odd   = 1'($urandom_range(0, 1));
         cfg_two_stop  = 1'($urandom_range(0, 1));
         cfg_msb_first = 1'($urandom_range(0, 1));
         cfg_invert    = 1'($urandom_range(0, 1));
         d  = 8'($urandom);
         bp = ($urandom_range(0, 3) == 0);
         bs = ($urandom_range(0, 4) == 0) ? (cfg_two_stop ? int'($urandom_range(1, 2)) : 1) : 0;
         frame_case(cfg_invert ? "R7" : (cfg_msb_first ? "R3" : "R2"), d, bp, bs);
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(negedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule